// File: doc/BRIEF.md
# Receive Idle Timeout Timer

This block watches a UART receive FIFO and raises a timeout when the line has gone quiet. Each time the FIFO logic stores a received byte, the block restarts a countdown. The countdown length is a 4-bit programmable count of whole character frames. One frame lasts one start bit, plus the data bits, plus the stop bits, all counted in baud ticks. The baud generator lies outside the block and supplies one tick per bit period.

When the countdown runs out, the timeout fires if the FIFO reports data ready, or if the control word forces it. Firing sets a sticky timeout flag and sends a one-cycle request to set the receive interrupt source. Software clears the flag by writing a one to bit 3 of the status word. The FIFO's own trigger-level interrupt cancels any running countdown, and clearing the enable bit does the same.

Top module: `rx_idle_timer`

## Requirements
- R1: After reset, `timeout_flag` and `rx_irq_set` are 0 and no countdown is running.
- R2: Control bit 7 enables the timer. While it is 0, no countdown runs, a running countdown is discarded, and setting it again does not resume the countdown until a byte is stored.
- R3: The countdown lasts control bits [15:12] times one character time. A character time is (`data_code` + 5) data bits, plus 2 stop bits when `two_stop` is 1 or 1 otherwise, plus one start bit, counted in baud ticks. Expiry happens on the baud tick that completes this count.
- R4: With control bits [15:12] equal to 0, expiry happens on the first baud tick after the restart.
- R5: At expiry the timeout fires only if `data_ready` is 1 or control bit 11 is 1. Otherwise the countdown ends with no effect.
- R6: Firing sets `timeout_flag` and pulses `rx_irq_set` high for one cycle. Both change on the clock edge that samples the expiring tick.
- R7: A status write (`sts_wr`) whose data has bit 3 set clears `timeout_flag`. A status write with bit 3 clear leaves the flag unchanged.
- R8: A stored byte (`byte_stored`) restarts the countdown from its full length, even if a countdown is already running.
- R9: A trigger-level interrupt (`trig_cancel`) cancels the countdown and blocks an expiry in the same cycle. It also wins over a `byte_stored` in the same cycle.
- R10: If firing and a status clear fall in the same cycle, `timeout_flag` ends up set.
- R11: After expiry, further baud ticks cause no further firing until another byte is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick | input | 1 | One-cycle pulse per bit period |
| byte_stored | input | 1 | Received byte written into the FIFO this cycle |
| ctrl | input | 16 | Control word: bit 7 enable, bit 11 force fire, bits [15:12] length in characters |
| data_code | input | 2 | Data bits minus 5 |
| two_stop | input | 1 | 1 selects two stop bits |
| data_ready | input | 1 | FIFO holds unread data |
| trig_cancel | input | 1 | Trigger-level receive interrupt raised this cycle |
| sts_wr | input | 1 | Status word write strobe |
| sts_wdata | input | 8 | Status write data; bit 3 clears the timeout flag |
| timeout_flag | output | 1 | Sticky timeout status |
| rx_irq_set | output | 1 | One-cycle request to set the receive interrupt source |

## Verification
Three collisions matter most: expiry against a software clear of the flag, a stored byte against a trigger-level cancel, and a stored byte against the expiring tick. The bench provokes each collision by driving both strobes in the same cycle. For the first collision it uses a zero-length timeout, so the expiring tick can be placed exactly. A behavioural model, compared on every clock, decides which action wins. Directed checks then read the flag afterwards: it must stay set after expiry meets a clear, and no interrupt may follow a push that met a cancel.

// File: rtl/rx_idle_timer.sv
module rx_idle_timer #(
  parameter int CTRL_W    = 16,
  parameter int STS_W     = 8,
  parameter int LEN_W     = 4,
  parameter int LEN_LSB   = 12,
  parameter int EN_BIT    = 7,
  parameter int FORCE_BIT = 11,
  parameter int FLAG_BIT  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              byte_stored,
  input  logic [CTRL_W-1:0] ctrl,
  input  logic [1:0]        data_code,
  input  logic              two_stop,
  input  logic              data_ready,
  input  logic              trig_cancel,
  input  logic              sts_wr,
  input  logic [STS_W-1:0]  sts_wdata,
  output logic              timeout_flag,
  output logic              rx_irq_set
);
  localparam int MAX_CHAR = 11;
  localparam int LEFT_W   = $clog2(((1 << LEN_W) - 1) * MAX_CHAR + 1);

  logic              armed;
  logic [LEFT_W-1:0] left;
  logic [3:0]        char_len;
  logic [LEFT_W-1:0] load_val;
  logic              en, expire, fire;

  assign en       = ctrl[EN_BIT];
  assign char_len = 4'd7 + {2'b00, data_code} + {3'b000, two_stop};
  assign load_val = LEFT_W'(ctrl[LEN_LSB +: LEN_W]) * LEFT_W'(char_len);
  assign expire   = armed & en & baud_tick & ~trig_cancel & (left <= LEFT_W'(1));
  assign fire     = expire & (data_ready | ctrl[FORCE_BIT]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed        <= 1'b0;
      left         <= '0;
      timeout_flag <= 1'b0;
      rx_irq_set   <= 1'b0;
    end else begin
      rx_irq_set <= fire;
      if (fire)
        timeout_flag <= 1'b1;
      else if (sts_wr && sts_wdata[FLAG_BIT])
        timeout_flag <= 1'b0;

      if (!en || trig_cancel) begin
        armed <= 1'b0;
      end else if (byte_stored) begin
        armed <= 1'b1;
        left  <= load_val;
      end else if (expire) begin
        armed <= 1'b0;
      end else if (armed && baud_tick) begin
        left <= left - LEFT_W'(1);
      end
    end
  end
endmodule

module rx_idle_timer_chk (
  input logic clk,
  input logic rst_n,
  input logic baud_tick,
  input logic en,
  input logic force_fire,
  input logic data_ready,
  input logic trig_cancel,
  input logic clr,
  input logic timeout_flag,
  input logic rx_irq_set
);
  assert_irq_sets_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq_set |-> timeout_flag);
  assert_flag_rise_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_flag) |-> rx_irq_set);
  assert_irq_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq_set |-> $past(baud_tick));
  assert_irq_cond_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq_set |-> $past(data_ready || force_fire));
  assert_disabled_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !rx_irq_set);
  assert_cancel_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    trig_cancel |=> !rx_irq_set);
  assert_clear_works_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!timeout_flag || rx_irq_set));
endmodule

bind rx_idle_timer rx_idle_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
  .en(ctrl[EN_BIT]), .force_fire(ctrl[FORCE_BIT]),
  .data_ready(data_ready), .trig_cancel(trig_cancel),
  .clr(sts_wr & sts_wdata[FLAG_BIT]),
  .timeout_flag(timeout_flag), .rx_irq_set(rx_irq_set)
);

// File: tb/sim_rx_idle_timer.sv
module sim_rx_idle_timer;
  logic clk = 0;
  logic rst_n = 0;
  logic baud_tick = 0, byte_stored = 0, two_stop = 0, data_ready = 0;
  logic trig_cancel = 0, sts_wr = 0;
  logic [15:0] ctrl = 0;
  logic [1:0]  data_code = 0;
  logic [7:0]  sts_wdata = 0;
  logic timeout_flag, rx_irq_set;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rx_idle_timer u0 (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .byte_stored(byte_stored),
    .ctrl(ctrl), .data_code(data_code), .two_stop(two_stop),
    .data_ready(data_ready), .trig_cancel(trig_cancel), .sts_wr(sts_wr),
    .sts_wdata(sts_wdata), .timeout_flag(timeout_flag), .rx_irq_set(rx_irq_set)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // behavioural reference
  int m_armed = 0, m_left = 0, m_flag = 0, m_irq = 0;
  always @(posedge clk) begin
    int clen;
    bit exp_now, fire_now;
    if (!rst_n) begin
      m_armed = 0; m_left = 0; m_flag = 0; m_irq = 0;
    end else begin
      clen = int'(data_code) + 5 + (two_stop ? 2 : 1) + 1;
      exp_now = (m_armed != 0) && ctrl[7] && baud_tick && !trig_cancel && (m_left <= 1);
      fire_now = exp_now && (data_ready || ctrl[11]);
      m_irq = fire_now ? 1 : 0;
      if (fire_now) m_flag = 1;
      else if (sts_wr && sts_wdata[3]) m_flag = 0;
      if (!ctrl[7] || trig_cancel) m_armed = 0;
      else if (byte_stored) begin m_armed = 1; m_left = int'(ctrl[15:12]) * clen; end
      else if (exp_now) m_armed = 0;
      else if (m_armed != 0 && baud_tick) m_left = m_left - 1;
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    chk("R6 model flag", int'(timeout_flag), m_flag);
    chk("R6 model irq", int'(rx_irq_set), m_irq);
  end

  function automatic logic [15:0] mk(bit en, bit frc, int len);
    logic [15:0] c = 0;
    c[7] = en; c[11] = frc; c[15:12] = 4'(len);
    return c;
  endfunction

  task automatic push();
    @(negedge clk) byte_stored = 1;
    @(negedge clk) byte_stored = 0;
  endtask

  task automatic ticks_until_fire(int max, output int n);
    n = 0;
    for (int i = 1; i <= max; i++) begin
      @(negedge clk) baud_tick = 1;
      @(negedge clk) baud_tick = 0;
      if (rx_irq_set) begin n = i; return; end
    end
  endtask

  task automatic sts_write(logic [7:0] d);
    @(negedge clk) begin sts_wr = 1; sts_wdata = d; end
    @(negedge clk) begin sts_wr = 0; sts_wdata = 0; end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 flag after reset", int'(timeout_flag), 0);
    chk("R1 irq after reset", int'(rx_irq_set), 0);
    ticks_until_fire(5, n);
    chk("R1 idle after reset", n, 0);

    // R3: 8 data, 1 stop -> 10 ticks per char, 2 chars
    data_code = 2'd3; two_stop = 0; data_ready = 1; ctrl = mk(1, 0, 2);
    push(); ticks_until_fire(60, n);
    chk("R3 8N1 x2 ticks", n, 20);
    chk("R6 flag set", int'(timeout_flag), 1);
    sts_write(8'hF7);
    chk("R7 bit3 clear write ignored", int'(timeout_flag), 1);
    sts_write(8'h08);
    chk("R7 clear flag", int'(timeout_flag), 0);
    ticks_until_fire(40, n);
    chk("R11 no refire", n, 0);

    // R3: 5 data, 2 stop -> 8 ticks, 3 chars
    data_code = 2'd0; two_stop = 1; ctrl = mk(1, 0, 3);
    push(); ticks_until_fire(60, n);
    chk("R3 5-2 x3 ticks", n, 24);
    sts_write(8'h08);

    // R3 maximum length: 11 ticks x 15
    data_code = 2'd3; two_stop = 1; ctrl = mk(1, 0, 15);
    push(); ticks_until_fire(200, n);
    chk("R3 max ticks", n, 165);
    sts_write(8'h08);

    ctrl = mk(1, 0, 0);
    push(); ticks_until_fire(10, n);
    chk("R4 zero field", n, 1);
    sts_write(8'h08);

    // R5: no data, no force
    data_ready = 0; data_code = 2'd3; two_stop = 0; ctrl = mk(1, 0, 1);
    push(); ticks_until_fire(40, n);
    chk("R5 silent expiry", n, 0);
    chk("R5 flag stays clear", int'(timeout_flag), 0);
    ctrl = mk(1, 1, 1);
    push(); ticks_until_fire(40, n);
    chk("R5 forced fire", n, 10);
    sts_write(8'h08);
    data_ready = 1;

    // R8 restart mid-count
    ctrl = mk(1, 0, 1);
    push(); ticks_until_fire(6, n);
    chk("R8 none before restart", n, 0);
    push(); ticks_until_fire(40, n);
    chk("R8 full length after restart", n, 10);
    sts_write(8'h08);

    // R2 disable discards countdown
    push(); ticks_until_fire(3, n);
    @(negedge clk) ctrl = mk(0, 0, 1);
    @(negedge clk) ctrl = mk(1, 0, 1);
    ticks_until_fire(40, n);
    chk("R2 disable cancels", n, 0);
    @(negedge clk) ctrl = mk(0, 0, 1);
    push();
    @(negedge clk) ctrl = mk(1, 0, 1);
    ticks_until_fire(40, n);
    chk("R2 push while disabled", n, 0);

    // R9 cancel, also against same-cycle push
    push(); ticks_until_fire(3, n);
    @(negedge clk) begin trig_cancel = 1; byte_stored = 1; end
    @(negedge clk) begin trig_cancel = 0; byte_stored = 0; end
    ticks_until_fire(40, n);
    chk("R9 cancel wins over push", n, 0);
    ctrl = mk(1, 0, 0);
    push();
    @(negedge clk) begin trig_cancel = 1; baud_tick = 1; end
    @(negedge clk) begin trig_cancel = 0; baud_tick = 0; end
    chk("R9 cancel blocks expiry", int'(rx_irq_set), 0);

    // R10 expiry vs clear, flag already set
    push(); ticks_until_fire(5, n);
    chk("R10 setup flag", int'(timeout_flag), 1);
    push();
    @(negedge clk) begin baud_tick = 1; sts_wr = 1; sts_wdata = 8'h08; end
    @(negedge clk) begin baud_tick = 0; sts_wr = 0; sts_wdata = 0; end
    chk("R10 irq on collision", int'(rx_irq_set), 1);
    chk("R10 flag stays set", int'(timeout_flag), 1);

    // push coincident with expiring tick: fires and restarts
    push();
    @(negedge clk) begin baud_tick = 1; byte_stored = 1; end
    @(negedge clk) begin baud_tick = 0; byte_stored = 0; end
    chk("R8 fire with restart", int'(rx_irq_set), 1);
    ticks_until_fire(5, n);
    chk("R8 restarted count", n, 1);

    repeat (3) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule